// File: doc/BRIEF.md
# Parallel Printer Port Register Block

This block is the host side of a byte-wide parallel printer port. A CPU reaches it through a small register bus with a 2-bit logical address, a write strobe, write data and combinational read data. Three logical registers sit behind that bus. The first holds the byte placed on the printer data lines. The second reports the printer status lines. The third drives the active-low handshake and control lines, plus two mode bits that are brought out for neighbouring logic.

Driver software works the port by polling. It writes a byte, then writes the control register twice to pulse the strobe low and high again. It reads the status register until the busy bit clears. Every pin the block drives comes straight from a flop, so a write never glitches a printer line. The status lines are asynchronous to the host clock, so each one passes through a two-flop synchronizer before it can be read.

Top module: `lpt_port_regs`

## Requirements
- R1: After reset the data pins are 0x00 and the control register holds 0x01. The strobe is therefore inactive (high). Auto line feed, init and select-in are driven low, and the interrupt-enable and bidirectional-mode outputs are 0.
- R2: A write to address 0 loads the data register, and the data pins show the new byte after that clock edge. A read of address 0 returns the last byte written.
- R3: A write to address 2 updates the control outputs after that clock edge. Bit 0 drives pr_strobe_no, bit 1 drives pr_autofd_no, bit 2 drives pr_init_no and bit 3 drives pr_selin_no. Bit 4 drives irq_en_o and bit 5 drives bidir_o. Each pin level equals the written bit.
- R4: A read of address 2 returns control bits 5..0 as last written, with bits 7..6 read as 0.
- R5: A read of address 1 returns the synchronized status. Bit 7 is busy, bit 6 is the acknowledge line, bit 5 is the paper line, bit 4 is select and bit 3 is error. Each bit is the raw pin level with no inversion, and bits 2..0 read 0.
- R6: A change on a status pin is not visible in a read after the first rising edge. It is visible after the second rising edge.
- R7: A write to address 1 changes neither the data pins nor any control output.
- R8: Address 3 reads as 0x00. A write to it changes neither the data pins nor any control output.
- R9: The data pins and control outputs hold their value in every cycle that has no write to their own address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Logical register address |
| wr_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| pr_data_o | output | 8 | Printer data lines |
| pr_strobe_no | output | 1 | Data strobe, active low |
| pr_autofd_no | output | 1 | Auto line feed, active low |
| pr_init_no | output | 1 | Printer init, active low |
| pr_selin_no | output | 1 | Select-in, active low |
| irq_en_o | output | 1 | Interrupt-enable control bit |
| bidir_o | output | 1 | Bidirectional-mode control bit |
| pr_busy_i | input | 1 | Printer busy |
| pr_ack_ni | input | 1 | Printer acknowledge, active low |
| pr_paper_ni | input | 1 | Printer paper line |
| pr_sel_i | input | 1 | Printer selected |
| pr_err_ni | input | 1 | Printer error, active low |

## Verification
A control bit stored in the wrong place, or with flipped polarity, appears on a printer pin one edge after the write. The bench compares all six control outputs as a vector after each control write. A stray write enable shows up as a pin that moves after a write to the status or spare address, and that is checked right after those writes. A wrong synchronizer depth shows as a status read that is correct one edge too early or too late. The bench therefore samples both after the first edge and after the second.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned CTRL_W = 6;
  localparam int unsigned STAT_W = 5;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_DATA  = 2'd0,
    ADDR_STAT  = 2'd1,
    ADDR_CTRL  = 2'd2,
    ADDR_SPARE = 2'd3
  } lpt_addr_e;

  localparam logic [DATA_W-1:0] DATA_RST = '0;
  // strobe high, everything else low
  localparam logic [CTRL_W-1:0] CTRL_RST = 6'b00_0001;
endpackage

// File: rtl/lpt_addr_dec.sv
module lpt_addr_dec
  import lpt_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  output logic              wr_data_o,
  output logic              wr_ctrl_o,
  output lpt_addr_e         sel_o
);
  always_comb begin
    sel_o     = lpt_addr_e'(addr_i);
    wr_data_o = wr_i && (sel_o == ADDR_DATA);
    wr_ctrl_o = wr_i && (sel_o == ADDR_CTRL);
  end
endmodule

// File: rtl/lpt_hold_reg.sv
module lpt_hold_reg #(
  parameter int unsigned      W   = 8,
  parameter logic [W-1:0]     RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST;
    else if (we_i) q_o <= d_i;
  end

  // R9
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));
endmodule

// File: rtl/lpt_status_sync.sv
module lpt_status_sync #(
  parameter int unsigned W      = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= async_i;
      else             stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];

  // checker: input held for STAGES edges must have arrived
  localparam int unsigned CNT_W = $clog2(STAGES + 1) + 1;
  logic [W-1:0]     prev_q;
  logic [CNT_W-1:0] held_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      held_q <= '0;
    end else begin
      prev_q <= async_i;
      if (async_i != prev_q)                   held_q <= '0;
      else if (held_q < CNT_W'(STAGES))        held_q <= held_q + 1'b1;
    end
  end

  // R6
  sync_arrive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held_q >= CNT_W'(STAGES)) |-> (sync_o == prev_q));
endmodule

// File: rtl/lpt_port_regs.sv
module lpt_port_regs
  import lpt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] pr_data_o,
  output logic              pr_strobe_no,
  output logic              pr_autofd_no,
  output logic              pr_init_no,
  output logic              pr_selin_no,
  output logic              irq_en_o,
  output logic              bidir_o,
  input  logic              pr_busy_i,
  input  logic              pr_ack_ni,
  input  logic              pr_paper_ni,
  input  logic              pr_sel_i,
  input  logic              pr_err_ni
);
  logic              wr_data, wr_ctrl;
  lpt_addr_e         sel;
  logic [DATA_W-1:0] data_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [STAT_W-1:0] stat_s;

  lpt_addr_dec u_dec (
    .addr_i   (addr_i),
    .wr_i     (wr_i),
    .wr_data_o(wr_data),
    .wr_ctrl_o(wr_ctrl),
    .sel_o    (sel)
  );

  lpt_hold_reg #(.W(DATA_W), .RST(DATA_RST)) u_data (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (wr_data),
    .d_i   (wdata_i),
    .q_o   (data_q)
  );

  lpt_hold_reg #(.W(CTRL_W), .RST(CTRL_RST)) u_ctrl (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (wr_ctrl),
    .d_i   (wdata_i[CTRL_W-1:0]),
    .q_o   (ctrl_q)
  );

  lpt_status_sync #(.W(STAT_W), .STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({pr_busy_i, pr_ack_ni, pr_paper_ni, pr_sel_i, pr_err_ni}),
    .sync_o (stat_s)
  );

  // pins straight from flops
  assign pr_data_o    = data_q;
  assign pr_strobe_no = ctrl_q[0];
  assign pr_autofd_no = ctrl_q[1];
  assign pr_init_no   = ctrl_q[2];
  assign pr_selin_no  = ctrl_q[3];
  assign irq_en_o     = ctrl_q[4];
  assign bidir_o      = ctrl_q[5];

  always_comb begin
    unique case (sel)
      ADDR_DATA: rdata_o = data_q;
      ADDR_STAT: rdata_o = {stat_s, {(DATA_W-STAT_W){1'b0}}};
      ADDR_CTRL: rdata_o = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
      default:   rdata_o = '0;
    endcase
  end

  // R2
  data_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADDR_DATA) |=> (pr_data_o == $past(wdata_i)));

  // R3
  strobe_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADDR_CTRL) |=> (pr_strobe_no == $past(wdata_i[0])
                                       && bidir_o == $past(wdata_i[5])));

  // R7
  stat_wr_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADDR_STAT) |=> ($stable(pr_data_o) && $stable(pr_strobe_no)
                                       && $stable(pr_init_no)));

  // R8
  spare_wr_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADDR_SPARE) |=> ($stable(pr_data_o) && $stable(irq_en_o)
                                        && $stable(pr_selin_no)));
endmodule

// File: tb/lpt_port_regs_tb.sv
module lpt_port_regs_tb;
  localparam time TCLK = 4ns;

  logic       clk = 0, rst_n = 0;
  logic [1:0] addr = 0;
  logic       wr = 0;
  logic [7:0] wdata = 0, rdata, pdata;
  logic       stb_n, afd_n, init_n, selin_n, irq_en, bidir;
  logic       busy = 0, ack_n = 0, paper_n = 0, sel = 0, err_n = 0;

  always #(TCLK/2) clk = ~clk;

  lpt_port_regs u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .wdata_i(wdata),
    .rdata_o(rdata), .pr_data_o(pdata), .pr_strobe_no(stb_n),
    .pr_autofd_no(afd_n), .pr_init_no(init_n), .pr_selin_no(selin_n),
    .irq_en_o(irq_en), .bidir_o(bidir), .pr_busy_i(busy), .pr_ack_ni(ack_n),
    .pr_paper_ni(paper_n), .pr_sel_i(sel), .pr_err_ni(err_n)
  );

  typedef struct {
    int         kind;   // 0 rdata, 1 data pins, 2 control vector
    logic [7:0] exp;
    string      req;
  } item_t;

  item_t q[$];
  event  chk_ev;
  int    checks = 0, errors = 0;
  bit    done = 0;

  function automatic logic [7:0] observe(int kind);
    case (kind)
      0:       return rdata;
      1:       return pdata;
      default: return {2'b00, bidir, irq_en, selin_n, init_n, afd_n, stb_n};
    endcase
  endfunction

  // monitor
  initial forever begin
    @(chk_ev);
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] got;
      it  = q.pop_front();
      got = observe(it.kind);
      checks++;
      if (got !== it.exp) begin
        errors++;
        $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.req, it.kind, got, it.exp);
      end
    end
  end

  task automatic expect_item(int kind, logic [7:0] exp, string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    q.push_back(it);
    #0.5ns;
    -> chk_ev;
    #0.1ns;
  endtask

  task automatic bus_write(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1;
    @(negedge clk);
    wr = 0;
  endtask

  task automatic read_expect(logic [1:0] a, logic [7:0] exp, string req);
    addr = a;
    expect_item(0, exp, req);
  endtask

  initial begin
    #(TCLK * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    expect_item(1, 8'h00, "R1");
    expect_item(2, 8'h01, "R1");
    read_expect(2'd2, 8'h01, "R1_R4");
    read_expect(2'd1, 8'h00, "R5");

    // R2 data register
    bus_write(2'd0, 8'hA5);
    expect_item(1, 8'hA5, "R2");
    read_expect(2'd0, 8'hA5, "R2");

    // R3 R4 control bits and readback
    bus_write(2'd2, 8'hFE);
    expect_item(2, 8'h3E, "R3");
    read_expect(2'd2, 8'h3E, "R4");
    bus_write(2'd2, 8'h05);
    expect_item(2, 8'h05, "R3");
    bus_write(2'd2, 8'h2A);
    expect_item(2, 8'h2A, "R3");
    bus_write(2'd2, 8'h05);

    // R7 status address write ignored
    bus_write(2'd1, 8'h77);
    expect_item(1, 8'hA5, "R7");
    expect_item(2, 8'h05, "R7");

    // R8 spare address
    bus_write(2'd3, 8'h33);
    expect_item(1, 8'hA5, "R8");
    expect_item(2, 8'h05, "R8");
    read_expect(2'd3, 8'h00, "R8");

    // R5 R6 status pattern one: busy=1 ack=0 paper=1 sel=1 err=0 -> B0
    @(negedge clk);
    busy = 1; ack_n = 0; paper_n = 1; sel = 1; err_n = 0;
    @(negedge clk);
    read_expect(2'd1, 8'h00, "R6");
    @(negedge clk);
    read_expect(2'd1, 8'hB0, "R5_R6");

    // pattern two: busy=0 ack=1 paper=0 sel=0 err=1 -> 48
    busy = 0; ack_n = 1; paper_n = 0; sel = 0; err_n = 1;
    @(negedge clk);
    read_expect(2'd1, 8'hB0, "R6");
    @(negedge clk);
    read_expect(2'd1, 8'h48, "R5");

    // R9 hold across idle cycles, status reads do not disturb
    bus_write(2'd0, 8'h5A);
    repeat (5) @(negedge clk);
    expect_item(1, 8'h5A, "R9");
    expect_item(2, 8'h05, "R9");

    // strobe pulse sequence
    bus_write(2'd2, 8'h04);
    expect_item(2, 8'h04, "R3");
    bus_write(2'd2, 8'h05);
    expect_item(2, 8'h05, "R3");
    expect_item(1, 8'h5A, "R9");

    @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule